// File: doc/BRIEF.md
# Byte register bank with set/clear alias addresses behind a serial slave

This block is a small control register file that sits behind a serial two-wire slave. The bit-level bus logic is outside it. It sees three events: a start of a write transfer, a byte sent by the bus master, and a request for a byte to return to the master. The first byte after a start is a register pointer. Every later byte writes the register the pointer selects, and every read returns it. Both then move the pointer forward by one.

Three control bytes each appear at three neighbouring addresses. The base address loads the byte. The next address ORs ones into it, and the one after that clears the bits that are one in the value. Each byte keeps only its implemented bits. Two single-purpose bytes near the top of the map store a few bits each. The last address is a read-only view of the lowest clock-control bit. Four identification bytes at the bottom of the map are constant. An error counter records every access the map cannot serve.

Top module: `i2c_alias_regbank`

## Requirements
- R1: After reset, and on any cycle with `start_i` high, the next byte on `tx_valid_i`/`tx_data_i` loads the pointer and writes no register. A byte in the same cycle as `start_i` counts as that pointer byte.
- R2: Each later byte writes the register at the pointer, and the pointer then steps by one. The pointer is 8 bits and wraps from 0xFF to 0x00.
- R3: `rx_req_i` returns the register at the pointer on `rx_data_o`, with `rx_valid_o` high one cycle later, and the pointer steps by one. A request in the same cycle as a byte is dropped: no `rx_valid_o`, and the pointer steps only once.
- R4: The control byte at 0x04 resets to 0x41 and keeps only bit 7 (mask 0x80). A write to 0x04 stores value AND mask. A write to 0x05 stores (old OR value) AND mask. A write to 0x06 stores (old AND NOT value) AND mask.
- R5: The control byte at 0x07 works like R4, with set alias 0x08, clear alias 0x09, reset value 0x10 and mask 0x61.
- R6: The control byte at 0xAC works like R4, with set alias 0xAD, clear alias 0xAE, reset value 0x00 and mask 0x20.
- R7: A read of any of the three addresses of a group returns that group's one storage byte.
- R8: Address 0xFD keeps only bit 0 and resets to 0x00. Address 0xFE keeps only bits 2:0 and resets to 0x02.
- R9: A read of 0xFF returns 0x00 with bit 0 replaced by bit 0 of 0xFE. A write to 0xFF is ignored.
- R10: Addresses 0x00 to 0x03 read 0x51, 0x04, 0x02 and 0xC0. Writes to them are ignored.
- R11: A read of an unmapped address returns 0x00. The following accesses each add one to `err_count_o`: a read of an unmapped address, and a write to an unmapped or read-only address (0x00 to 0x03, 0xFF). The counter saturates at all ones. Pointer bytes never count.
- R12: Reset is synchronous and active high. It restores every reset value above, clears the pointer to 0x00, and clears `err_count_o` and `rx_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start of a write transfer |
| tx_valid_i | input | 1 | Byte from the master is present |
| tx_data_i | input | 8 | Byte from the master |
| rx_req_i | input | 1 | Master asks for a byte |
| rx_valid_o | output | 1 | Read byte valid, one cycle after the request |
| rx_data_o | output | 8 | Read byte |
| err_count_o | output | ERR_W | Saturating count of accesses the map cannot serve |

## Verification
Two collisions share a cycle. In the first, a start event and a byte arrive together. The bench drives both in one cycle, then reads back through the pointer to show that the byte became the pointer and was not stored. In the second, a byte and a read request arrive together. The bench drives both in the same cycle and expects no `rx_valid_o` on the next cycle. A following read must return the next address, and a readback must show the write took effect, which proves the pointer stepped exactly once.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int BYTE_W  = 8;
    localparam int NUM_GRP = 3;
    localparam int NUM_ID  = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        AK_NONE,
        AK_ID,
        AK_DIRECT,
        AK_SET,
        AK_CLR,
        AK_PWR,
        AK_CLK,
        AK_CLKBIT
    } acc_kind_e;

    typedef enum logic [1:0] {
        OP_LOAD,
        OP_OR,
        OP_ANDN
    } wop_e;

    typedef struct packed {
        acc_kind_e   kind;
        logic [1:0]  grp;
        logic [1:0]  id;
    } dec_t;

    // Alias groups: base address, base+1 sets, base+2 clears
    localparam byte_t GRP_BASE [NUM_GRP] = '{8'h04, 8'h07, 8'hAC};
    localparam byte_t GRP_MASK [NUM_GRP] = '{8'h80, 8'h61, 8'h20};
    localparam byte_t GRP_RST  [NUM_GRP] = '{8'h41, 8'h10, 8'h00};

    localparam byte_t ID_VAL [NUM_ID] = '{8'h51, 8'h04, 8'h02, 8'hC0};

    localparam byte_t PWR_ADDR    = 8'hFD;
    localparam byte_t CLK_ADDR    = 8'hFE;
    localparam byte_t CLKBIT_ADDR = 8'hFF;
    localparam byte_t PWR_MASK    = 8'h01;
    localparam byte_t CLK_MASK    = 8'h07;
    localparam byte_t PWR_RST     = 8'h00;
    localparam byte_t CLK_RST     = 8'h02;

    function automatic dec_t decode(input byte_t a);
        dec_t d;
        d.kind = AK_NONE;
        d.grp  = 2'd0;
        d.id   = a[1:0];
        if (a < byte_t'(NUM_ID)) begin
            d.kind = AK_ID;
        end
        for (int g = 0; g < NUM_GRP; g++) begin
            if (a == GRP_BASE[g]) begin
                d.kind = AK_DIRECT;
                d.grp  = 2'(g);
            end else if (a == byte_t'(GRP_BASE[g] + 8'd1)) begin
                d.kind = AK_SET;
                d.grp  = 2'(g);
            end else if (a == byte_t'(GRP_BASE[g] + 8'd2)) begin
                d.kind = AK_CLR;
                d.grp  = 2'(g);
            end
        end
        if (a == PWR_ADDR)    d.kind = AK_PWR;
        if (a == CLK_ADDR)    d.kind = AK_CLK;
        if (a == CLKBIT_ADDR) d.kind = AK_CLKBIT;
        return d;
    endfunction

    function automatic byte_t apply_op(input byte_t cur, input byte_t v,
                                       input wop_e op, input byte_t mask);
        byte_t r;
        case (op)
            OP_OR:   r = cur | v;
            OP_ANDN: r = cur & ~v;
            default: r = v;
        endcase
        return r & mask;
    endfunction

    function automatic logic is_writable(input acc_kind_e k);
        return (k == AK_DIRECT) || (k == AK_SET) || (k == AK_CLR) ||
               (k == AK_PWR) || (k == AK_CLK);
    endfunction

endpackage

// File: rtl/regbank_ptr.sv
module regbank_ptr
    import regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  tx_valid_i,
    input  byte_t tx_data_i,
    input  logic  rx_req_i,
    output byte_t ptr_o,
    output logic  wr_en_o,
    output byte_t wr_data_o,
    output logic  rd_en_o
);

    logic  expect_ptr_q;
    byte_t ptr_q;
    logic  load_ptr;

    assign load_ptr  = tx_valid_i && (start_i || expect_ptr_q);
    assign wr_en_o   = tx_valid_i && !load_ptr;
    assign rd_en_o   = rx_req_i && !tx_valid_i;
    assign wr_data_o = tx_data_i;
    assign ptr_o     = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q        <= '0;
            expect_ptr_q <= 1'b1;
        end else begin
            if (load_ptr) begin
                ptr_q        <= tx_data_i;
                expect_ptr_q <= 1'b0;
            end else begin
                if (start_i) expect_ptr_q <= 1'b1;
                if (wr_en_o || rd_en_o) ptr_q <= ptr_q + 8'd1;
            end
        end
    end

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_i && start_i) |=> (ptr_q == $past(tx_data_i))); // R1

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o || rd_en_o) |=> (ptr_q == byte_t'($past(ptr_q) + 8'd1))); // R2

    AST_PTR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!tx_valid_i && !rx_req_i) |=> $stable(ptr_q)); // R2

    AST_NO_DUAL: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_o && rd_en_o)); // R3

endmodule

// File: rtl/regbank_byte.sv
module regbank_byte
    import regbank_pkg::*;
#(
    parameter byte_t MASK = 8'hFF,
    parameter byte_t RST  = 8'h00
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we_i,
    input  wop_e  op_i,
    input  byte_t data_i,
    output byte_t q_o
);

    byte_t q;

    always_ff @(posedge clk) begin
        if (rst)       q <= RST;
        else if (we_i) q <= apply_op(q, data_i, op_i, MASK);
    end

    assign q_o = q;

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
        ((q & ~MASK) & ~$past(q)) == '0); // R4

    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(q)); // R7

endmodule

// File: rtl/regbank_errcnt.sv
module regbank_errcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] MAX = '1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                       cnt <= '0;
        else if (inc_i && cnt != MAX)  cnt <= cnt + 1'b1;
    end

    assign count_o = cnt;

    AST_ERR_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc_i && cnt != MAX) |=> (cnt == $past(cnt) + 1'b1)); // R11

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        !inc_i |=> $stable(cnt)); // R11

endmodule

// File: rtl/i2c_alias_regbank.sv
module i2c_alias_regbank
    import regbank_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             tx_valid_i,
    input  logic [7:0]       tx_data_i,
    input  logic             rx_req_i,
    output logic             rx_valid_o,
    output logic [7:0]       rx_data_o,
    output logic [ERR_W-1:0] err_count_o
);

    byte_t ptr;
    logic  wr_en;
    logic  rd_en;
    byte_t wr_data;
    dec_t  dec;
    wop_e  grp_op;
    byte_t grp_q [NUM_GRP];
    byte_t pwr_q;
    byte_t clk_q;
    byte_t rd_mux;
    logic  bad_access;
    logic  rx_valid_q;
    byte_t rx_data_q;

    regbank_ptr u_ptr (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .tx_valid_i(tx_valid_i),
        .tx_data_i (tx_data_i),
        .rx_req_i  (rx_req_i),
        .ptr_o     (ptr),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data),
        .rd_en_o   (rd_en)
    );

    // One decoder serves both directions: reads and writes use the same pointer
    assign dec = decode(ptr);

    always_comb begin
        case (dec.kind)
            AK_SET:  grp_op = OP_OR;
            AK_CLR:  grp_op = OP_ANDN;
            default: grp_op = OP_LOAD;
        endcase
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic we_g;
        assign we_g = wr_en && (dec.grp == 2'(g)) &&
                      ((dec.kind == AK_DIRECT) || (dec.kind == AK_SET) ||
                       (dec.kind == AK_CLR));
        regbank_byte #(
            .MASK(GRP_MASK[g]),
            .RST (GRP_RST[g])
        ) u_byte (
            .clk   (clk),
            .rst   (rst),
            .we_i  (we_g),
            .op_i  (grp_op),
            .data_i(wr_data),
            .q_o   (grp_q[g])
        );
    end

    regbank_byte #(.MASK(PWR_MASK), .RST(PWR_RST)) u_pwr (
        .clk   (clk),
        .rst   (rst),
        .we_i  (wr_en && dec.kind == AK_PWR),
        .op_i  (OP_LOAD),
        .data_i(wr_data),
        .q_o   (pwr_q)
    );

    regbank_byte #(.MASK(CLK_MASK), .RST(CLK_RST)) u_clk (
        .clk   (clk),
        .rst   (rst),
        .we_i  (wr_en && dec.kind == AK_CLK),
        .op_i  (OP_LOAD),
        .data_i(wr_data),
        .q_o   (clk_q)
    );

    always_comb begin
        rd_mux = '0;
        case (dec.kind)
            AK_ID:     rd_mux = ID_VAL[dec.id];
            AK_PWR:    rd_mux = pwr_q;
            AK_CLK:    rd_mux = clk_q;
            AK_CLKBIT: rd_mux = {7'b0, clk_q[0]};
            AK_DIRECT, AK_SET, AK_CLR: begin
                for (int g = 0; g < NUM_GRP; g++) begin
                    if (dec.grp == 2'(g)) rd_mux = grp_q[g];
                end
            end
            default:   rd_mux = '0;
        endcase
    end

    assign bad_access = (wr_en && !is_writable(dec.kind)) ||
                        (rd_en && (dec.kind == AK_NONE));

    regbank_errcnt #(.W(ERR_W)) u_err (
        .clk    (clk),
        .rst    (rst),
        .inc_i  (bad_access),
        .count_o(err_count_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
        end else begin
            rx_valid_q <= rd_en;
            if (rd_en) rx_data_q <= rd_mux;
        end
    end

    assign rx_valid_o = rx_valid_q;
    assign rx_data_o  = rx_data_q;

    AST_RX_ACK: assert property (@(posedge clk) disable iff (rst)
        (rx_req_i && !tx_valid_i) |=> rx_valid_o); // R3

    AST_RX_DROP: assert property (@(posedge clk) disable iff (rst)
        (rx_req_i && tx_valid_i) |=> !rx_valid_o); // R3

    AST_CLKBIT_UPPER: assert property (@(posedge clk) disable iff (rst)
        (rd_en && ptr == CLKBIT_ADDR) |=> (rx_data_o[7:1] == 7'd0)); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && dec.kind == AK_NONE) |=> (rx_data_o == 8'h00)); // R11

endmodule

// File: tb/i2c_alias_regbank_tb.sv
module i2c_alias_regbank_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       start_i;
    logic       tx_valid_i;
    logic [7:0] tx_data_i;
    logic       rx_req_i;
    logic       rx_valid_o;
    logic [7:0] rx_data_o;
    logic [7:0] err_count_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;   // 125 MHz

    i2c_alias_regbank #(.ERR_W(8)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .tx_valid_i (tx_valid_i),
        .tx_data_i  (tx_data_i),
        .rx_req_i   (rx_req_i),
        .rx_valid_o (rx_valid_o),
        .rx_data_o  (rx_data_o),
        .err_count_o(err_count_o)
    );

    // op codes: 0 = start with pointer byte, 1 = data byte, 2 = read and compare
    localparam int NV = 63;
    localparam logic [21:0] VEC [NV] = '{
        {4'd12, 2'd0, 8'h00, 8'h00},
        {4'd10, 2'd2, 8'h00, 8'h51},  // R10 identification bytes
        {4'd10, 2'd2, 8'h00, 8'h04},
        {4'd10, 2'd2, 8'h00, 8'h02},
        {4'd10, 2'd2, 8'h00, 8'hC0},
        {4'd12, 2'd2, 8'h00, 8'h41},  // R12 reset values of groups
        {4'd7,  2'd2, 8'h00, 8'h41},  // R7 aliases read the same byte
        {4'd7,  2'd2, 8'h00, 8'h41},
        {4'd12, 2'd2, 8'h00, 8'h10},
        {4'd7,  2'd2, 8'h00, 8'h10},
        {4'd7,  2'd2, 8'h00, 8'h10},
        {4'd12, 2'd0, 8'hFE, 8'h00},
        {4'd12, 2'd2, 8'h00, 8'h02},
        {4'd9,  2'd2, 8'h00, 8'h00},  // R9 view of bit 0 after reset
        {4'd4,  2'd0, 8'h04, 8'h00},  // R4 direct, set, clear
        {4'd4,  2'd1, 8'hFF, 8'h00},
        {4'd4,  2'd1, 8'h01, 8'h00},
        {4'd4,  2'd1, 8'h80, 8'h00},
        {4'd4,  2'd0, 8'h04, 8'h00},
        {4'd4,  2'd2, 8'h00, 8'h00},
        {4'd4,  2'd0, 8'h05, 8'h00},
        {4'd4,  2'd1, 8'h80, 8'h00},
        {4'd7,  2'd2, 8'h00, 8'h80},
        {4'd5,  2'd0, 8'h07, 8'h00},  // R5
        {4'd5,  2'd1, 8'hFF, 8'h00},
        {4'd5,  2'd0, 8'h09, 8'h00},
        {4'd5,  2'd1, 8'h21, 8'h00},
        {4'd7,  2'd0, 8'h08, 8'h00},
        {4'd7,  2'd2, 8'h00, 8'h40},
        {4'd5,  2'd0, 8'h08, 8'h00},
        {4'd5,  2'd1, 8'h01, 8'h00},
        {4'd5,  2'd0, 8'h07, 8'h00},
        {4'd5,  2'd2, 8'h00, 8'h41},
        {4'd6,  2'd0, 8'hAC, 8'h00},  // R6
        {4'd6,  2'd2, 8'h00, 8'h00},
        {4'd6,  2'd0, 8'hAD, 8'h00},
        {4'd6,  2'd1, 8'hFF, 8'h00},
        {4'd6,  2'd0, 8'hAC, 8'h00},
        {4'd6,  2'd2, 8'h00, 8'h20},
        {4'd6,  2'd0, 8'hAE, 8'h00},
        {4'd6,  2'd1, 8'h20, 8'h00},
        {4'd7,  2'd0, 8'hAD, 8'h00},
        {4'd7,  2'd2, 8'h00, 8'h00},
        {4'd8,  2'd0, 8'hFD, 8'h00},  // R8
        {4'd8,  2'd1, 8'hFF, 8'h00},
        {4'd8,  2'd1, 8'hFF, 8'h00},
        {4'd9,  2'd1, 8'h55, 8'h00},  // write to 0xFF ignored
        {4'd2,  2'd2, 8'h00, 8'h51},  // R2 pointer wrapped to 0x00
        {4'd8,  2'd0, 8'hFD, 8'h00},
        {4'd8,  2'd2, 8'h00, 8'h01},
        {4'd8,  2'd2, 8'h00, 8'h07},
        {4'd9,  2'd2, 8'h00, 8'h01},
        {4'd9,  2'd0, 8'hFE, 8'h00},
        {4'd9,  2'd1, 8'h06, 8'h00},
        {4'd9,  2'd2, 8'h00, 8'h00},
        {4'd10, 2'd0, 8'h00, 8'h00},
        {4'd10, 2'd1, 8'hAA, 8'h00},
        {4'd10, 2'd0, 8'h00, 8'h00},
        {4'd10, 2'd2, 8'h00, 8'h51},
        {4'd11, 2'd0, 8'h40, 8'h00},  // R11 unmapped
        {4'd11, 2'd1, 8'h12, 8'h00},
        {4'd11, 2'd0, 8'h40, 8'h00},
        {4'd11, 2'd2, 8'h00, 8'h00}
    };

    task automatic chk(input int req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL R%0d actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic st, input logic tv, input logic [7:0] d,
                        input logic rr);
        @(negedge clk);
        start_i = st; tx_valid_i = tv; tx_data_i = d; rx_req_i = rr;
        @(negedge clk);
        start_i = 1'b0; tx_valid_i = 1'b0; tx_data_i = 8'h00; rx_req_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; tx_valid_i = 1'b0; tx_data_i = 8'h00; rx_req_i = 1'b0;
        do_reset();
        chk(12, int'(err_count_o), 0);   // R12
        chk(12, int'(rx_valid_o), 0);    // R12

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][17:16])
                2'd0: step(1'b1, 1'b1, VEC[i][15:8], 1'b0);
                2'd1: step(1'b0, 1'b1, VEC[i][15:8], 1'b0);
                default: begin
                    step(1'b0, 1'b0, 8'h00, 1'b1);
                    chk(int'(VEC[i][21:18]), int'(rx_data_o), int'(VEC[i][7:0]));
                end
            endcase
        end
        chk(11, int'(err_count_o), 4);   // R11: writes 0xFF, 0x00, 0x40 and read 0x40

        // R1: start alone, then the next byte is the pointer
        step(1'b1, 1'b0, 8'h00, 1'b0);
        step(1'b0, 1'b1, 8'h07, 1'b0);
        step(1'b0, 1'b0, 8'h00, 1'b1);
        chk(3, int'(rx_valid_o), 1);     // R3
        chk(1, int'(rx_data_o), 8'h41);  // R1

        // R3: byte and read request in one cycle
        step(1'b1, 1'b1, 8'hFD, 1'b0);
        step(1'b0, 1'b1, 8'h00, 1'b1);
        chk(3, int'(rx_valid_o), 0);
        step(1'b0, 1'b0, 8'h00, 1'b1);
        chk(3, int'(rx_data_o), 8'h06);  // pointer stepped once to 0xFE
        step(1'b1, 1'b1, 8'hFD, 1'b0);
        step(1'b0, 1'b0, 8'h00, 1'b1);
        chk(8, int'(rx_data_o), 8'h00);  // R8 write in the collision landed

        // R11: counter saturates
        for (int r = 0; r < 3; r++) begin
            step(1'b1, 1'b1, 8'h40, 1'b0);
            for (int k = 0; k < 100; k++) step(1'b0, 1'b0, 8'h00, 1'b1);
        end
        chk(11, int'(err_count_o), 255);

        // R12 and R1: reset restores values; first byte is a pointer without start
        do_reset();
        chk(12, int'(err_count_o), 0);
        chk(12, int'(rx_valid_o), 0);
        step(1'b0, 1'b1, 8'h07, 1'b0);
        step(1'b0, 1'b0, 8'h00, 1'b1);
        chk(1, int'(rx_data_o), 8'h10);
        step(1'b1, 1'b1, 8'h04, 1'b0);
        step(1'b0, 1'b0, 8'h00, 1'b1);
        chk(12, int'(rx_data_o), 8'h41);
        chk(12, int'(err_count_o), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule